// File: doc/BRIEF.md
# Posted Write Buffer with Deferred Retirement

This block holds a single posted memory write: a 144-bit data word (sixteen 9-bit bytes), its bank and column address, and a per-byte protect mask. A write command addressed to this device loads the entry. The entry is not written into the sense-amplifier storage straight away. It is retired later, in the same cycle as a column command on which the storage port is free. A read to this device keeps that port busy, so no retirement can happen during it. On any other column command, retirement happens in that command's slot.

The retire interface gives a one-cycle strobe together with the stored bank, column, data and byte enables. The surrounding logic applies these to the sense-amplifier row. A read to this device can hit the bank and column still held in the buffer. In that case the block merges the buffered bytes over the array data supplied on `arr_data_i`, so the read never returns stale data.

Top module: `posted_wbuf`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the buffer is empty and `ret_o` stays low, even on a valid column command.
- R2: A valid command with `cop_i` = 2'b01 (write) and `same_dev_i` high loads `wr_data_i`, `cmd_bank_i`, `cmd_col_i` and `wr_mask_i`. The values presented on the later retirement are exactly these.
- R3: While the buffer is full, a valid column command retires the entry in that same cycle unless R5 applies. Retirement raises `ret_o` with the stored bank, column and data. A no-operation (2'b00 or 2'b11, either device), a write to another device and a read to another device all retire. The buffer is then empty, unless R4 applies.
- R4: A write to this device that arrives while the buffer is full retires the old entry in that cycle and captures the new write at the clock edge.
- R5: A valid read (`cop_i` = 2'b10) with `same_dev_i` high never raises `ret_o`, and a held entry survives it unchanged.
- R6: `ret_be_o[i]` is the inverse of the stored `wr_mask_i[i]`. A mask bit of 1 protects byte i, which occupies data bits [9i+8:9i].
- R7: No retirement strobe is issued while the buffer is empty.
- R8: On a read to this device, `rd_data_o` equals `arr_data_i`, except on a hit. A hit is a full buffer with matching bank and column. On a hit, every byte that is enabled in the buffered entry is taken from the buffer instead.
- R9: With `cop_valid_i` low, nothing retires and nothing is captured. A write to another device retires a held entry but captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cop_valid_i | input | 1 | A column command occupies this cycle |
| cop_i | input | 2 | Column command: 00 no-op, 01 write, 10 read, 11 no-op |
| same_dev_i | input | 1 | Command addresses this device |
| cmd_bank_i | input | 2 | Bank of the command |
| cmd_col_i | input | 7 | Column (data word index) of the command |
| wr_data_i | input | 144 | Write data, captured on a local write |
| wr_mask_i | input | 16 | Per-byte protect mask of the write |
| arr_data_i | input | 144 | Array word read at the command address |
| rd_data_o | output | 144 | Read data after forwarding merge |
| ret_o | output | 1 | Retire strobe |
| ret_bank_o | output | 2 | Bank of the retiring write |
| ret_col_o | output | 7 | Column of the retiring write |
| ret_data_o | output | 144 | Data of the retiring write |
| ret_be_o | output | 16 | Byte enables of the retiring write |

## Verification
The bench sweeps every combination of command code, device select, valid flag and buffer occupancy. This catches a design that retires during a local read, which would corrupt the row while it is being read. It also catches one that issues strobes from an empty buffer, which would write garbage into the array. Back-to-back local writes target a design that drops the old entry when a new one arrives, or that captures before retiring. Walking and inverted masks, including all-clear and all-set, are applied through both retirement and forwarding. They expose an inverted enable sense or a byte-lane slip, and also a forward that ignores the column or bank match and returns buffered bytes for the wrong word.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  parameter int unsigned NUM_BYTES = 16;
  parameter int unsigned BYTE_W    = 9;
  parameter int unsigned BANK_W    = 2;
  parameter int unsigned COL_W     = 7;

  typedef enum logic [1:0] {
    COP_NOP = 2'b00,
    COP_WR  = 2'b01,
    COP_RD  = 2'b10,
    COP_RSV = 2'b11
  } cop_e;
endpackage

// File: rtl/wbuf_ctl.sv
module wbuf_ctl
  import wbuf_pkg::*;
(
  input  logic       cop_valid_i,
  input  logic [1:0] cop_i,
  input  logic       same_dev_i,
  input  logic       valid_i,
  output logic       retire_o,
  output logic       capture_o,
  output logic       rd_local_o
);
  always_comb begin
    rd_local_o = cop_valid_i && (cop_e'(cop_i) == COP_RD) && same_dev_i;
    capture_o  = cop_valid_i && (cop_e'(cop_i) == COP_WR) && same_dev_i;
    // storage port is busy only during a local read
    retire_o   = valid_i && cop_valid_i && !rd_local_o;
  end
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int unsigned NUM_BYTES = 16,
  parameter int unsigned BYTE_W    = 9,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned COL_W     = 7,
  localparam int unsigned DATA_W   = NUM_BYTES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 capture_i,
  input  logic                 retire_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [COL_W-1:0]     col_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic [NUM_BYTES-1:0] mask_i,
  output logic                 valid_o,
  output logic [BANK_W-1:0]    bank_o,
  output logic [COL_W-1:0]     col_o,
  output logic [DATA_W-1:0]    data_o,
  output logic [NUM_BYTES-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        valid_o <= 1'b0;
    else if (capture_i) valid_o <= 1'b1;
    else if (retire_i)  valid_o <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (capture_i) begin
      bank_o <= bank_i;
      col_o  <= col_i;
      data_o <= data_i;
      mask_o <= mask_i;
    end
  end
endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge #(
  parameter int unsigned NUM_BYTES = 16,
  parameter int unsigned BYTE_W    = 9,
  localparam int unsigned DATA_W   = NUM_BYTES * BYTE_W
) (
  input  logic [DATA_W-1:0]    base_i,
  input  logic [DATA_W-1:0]    over_i,
  input  logic [NUM_BYTES-1:0] en_i,
  output logic [DATA_W-1:0]    out_o
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    assign out_o[g*BYTE_W +: BYTE_W] = en_i[g] ? over_i[g*BYTE_W +: BYTE_W]
                                               : base_i[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/posted_wbuf.sv
module posted_wbuf #(
  parameter int unsigned NUM_BYTES = wbuf_pkg::NUM_BYTES,
  parameter int unsigned BYTE_W    = wbuf_pkg::BYTE_W,
  parameter int unsigned BANK_W    = wbuf_pkg::BANK_W,
  parameter int unsigned COL_W     = wbuf_pkg::COL_W,
  localparam int unsigned DATA_W   = NUM_BYTES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cop_valid_i,
  input  logic [1:0]           cop_i,
  input  logic                 same_dev_i,
  input  logic [BANK_W-1:0]    cmd_bank_i,
  input  logic [COL_W-1:0]     cmd_col_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [NUM_BYTES-1:0] wr_mask_i,
  input  logic [DATA_W-1:0]    arr_data_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 ret_o,
  output logic [BANK_W-1:0]    ret_bank_o,
  output logic [COL_W-1:0]     ret_col_o,
  output logic [DATA_W-1:0]    ret_data_o,
  output logic [NUM_BYTES-1:0] ret_be_o
);
  logic                 valid_q;
  logic                 retire, capture, rd_local, fwd_hit;
  logic [NUM_BYTES-1:0] mask_q, fwd_en;

  wbuf_ctl u_ctl (
    .cop_valid_i (cop_valid_i),
    .cop_i       (cop_i),
    .same_dev_i  (same_dev_i),
    .valid_i     (valid_q),
    .retire_o    (retire),
    .capture_o   (capture),
    .rd_local_o  (rd_local)
  );

  wbuf_store #(
    .NUM_BYTES (NUM_BYTES),
    .BYTE_W    (BYTE_W),
    .BANK_W    (BANK_W),
    .COL_W     (COL_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .retire_i  (retire),
    .bank_i    (cmd_bank_i),
    .col_i     (cmd_col_i),
    .data_i    (wr_data_i),
    .mask_i    (wr_mask_i),
    .valid_o   (valid_q),
    .bank_o    (ret_bank_o),
    .col_o     (ret_col_o),
    .data_o    (ret_data_o),
    .mask_o    (mask_q)
  );

  assign ret_o    = retire;
  assign ret_be_o = ~mask_q;
  assign fwd_hit  = rd_local && valid_q &&
                    (ret_bank_o == cmd_bank_i) && (ret_col_o == cmd_col_i);
  assign fwd_en   = fwd_hit ? ~mask_q : '0;

  wbuf_merge #(
    .NUM_BYTES (NUM_BYTES),
    .BYTE_W    (BYTE_W)
  ) u_fwd (
    .base_i (arr_data_i),
    .over_i (ret_data_o),
    .en_i   (fwd_en),
    .out_o  (rd_data_o)
  );
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned COL_W  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cop_valid_i,
  input logic [1:0]        cop_i,
  input logic              same_dev_i,
  input logic              valid_q,
  input logic              ret_o,
  input logic [BANK_W-1:0] ret_bank_o,
  input logic [COL_W-1:0]  ret_col_o
);
  AST_EMPTY_NO_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> !ret_o); // R7
  AST_LOCAL_RD_NO_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_valid_i && cop_i == 2'b10 && same_dev_i) |-> !ret_o); // R5
  AST_LOCAL_RD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_valid_i && cop_i == 2'b10 && same_dev_i && valid_q) |=> valid_q); // R5
  AST_WR_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_valid_i && cop_i == 2'b01 && same_dev_i) |=> valid_q); // R2
  AST_FULL_WR_RETIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && cop_valid_i && cop_i == 2'b01 && same_dev_i) |-> ret_o); // R4
  AST_RET_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_o && !(cop_i == 2'b01 && same_dev_i)) |=> !valid_q); // R3
  AST_IDLE_NO_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cop_valid_i |-> !ret_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cop_valid_i |=> ($stable(valid_q) && $stable(ret_bank_o) && $stable(ret_col_o))); // R9
endmodule

bind posted_wbuf wbuf_chk #(.BANK_W(BANK_W), .COL_W(COL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cop_valid_i (cop_valid_i),
  .cop_i       (cop_i),
  .same_dev_i  (same_dev_i),
  .valid_q     (valid_q),
  .ret_o       (ret_o),
  .ret_bank_o  (ret_bank_o),
  .ret_col_o   (ret_col_o)
);

// File: tb/posted_wbuf_test.sv
module posted_wbuf_test;
  localparam int DW = 144;
  localparam int NB = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cop_valid_i = 1'b0;
  logic [1:0]    cop_i = 2'b00;
  logic          same_dev_i = 1'b0;
  logic [1:0]    cmd_bank_i = '0;
  logic [6:0]    cmd_col_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [NB-1:0] wr_mask_i = '0;
  logic [DW-1:0] arr_data_i = '0;
  logic [DW-1:0] rd_data_o, ret_data_o;
  logic          ret_o;
  logic [1:0]    ret_bank_o;
  logic [6:0]    ret_col_o;
  logic [NB-1:0] ret_be_o;

  posted_wbuf uut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] mem [512];
  logic          mv;
  logic [1:0]    mbank;
  logic [6:0]    mcol;
  logic [DW-1:0] mdata;
  logic [NB-1:0] mmask;

  function automatic logic [DW-1:0] pat(int s);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) r[b*9 +: 9] = 9'((s * 37 + b * 11 + 5) & 511);
    return r;
  endfunction

  function automatic logic [DW-1:0] mix(logic [DW-1:0] base, logic [DW-1:0] over,
                                        logic [NB-1:0] en);
    logic [DW-1:0] r = base;
    for (int b = 0; b < NB; b++) if (en[b]) r[b*9 +: 9] = over[b*9 +: 9];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] op, input logic sd,
                      input logic [1:0] bk, input logic [6:0] cl,
                      input logic [DW-1:0] d, input logic [NB-1:0] m);
    logic rdl, eret, cap;
    string tag;
    @(negedge clk_i);
    cop_valid_i = v; cop_i = op; same_dev_i = sd;
    cmd_bank_i = bk; cmd_col_i = cl; wr_data_i = d; wr_mask_i = m;
    arr_data_i = mem[{bk, cl}];
    #1;
    rdl  = v && op == 2'b10 && sd;
    cap  = v && op == 2'b01 && sd;
    eret = mv && v && !rdl;
    if (!mv)           tag = "R7";
    else if (!v)       tag = "R9";
    else if (rdl)      tag = "R5";
    else if (cap)      tag = "R4";
    else if (op == 2'b01) tag = "R9";
    else               tag = "R3";
    check(ret_o === eret, tag, DW'(ret_o), DW'(eret));
    if (eret) begin
      check(ret_bank_o === mbank && ret_col_o === mcol, "R3",
            DW'({ret_bank_o, ret_col_o}), DW'({mbank, mcol}));
      check(ret_data_o === mdata, "R2", ret_data_o, mdata);
      check(ret_be_o === ~mmask, "R6", DW'(ret_be_o), DW'(~mmask));
      mem[{mbank, mcol}] = mix(mem[{mbank, mcol}], mdata, ~mmask);
      mv = 1'b0;
    end
    if (rdl) begin
      logic [DW-1:0] er;
      er = (mv && mbank == bk && mcol == cl) ? mix(mem[{bk, cl}], mdata, ~mmask)
                                             : mem[{bk, cl}];
      check(rd_data_o === er, "R8", rd_data_o, er);
    end
    if (cap) begin
      mv = 1'b1; mbank = bk; mcol = cl; mdata = d; mmask = m;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = pat(i + 1000);
    mv = 1'b0; mbank = '0; mcol = '0; mdata = '0; mmask = '0;
    // R1: reset holds buffer empty even with a command present
    repeat (2) @(negedge clk_i);
    cop_valid_i = 1'b1; cop_i = 2'b01; same_dev_i = 1'b1;
    @(negedge clk_i); #1;
    check(ret_o === 1'b0, "R1", DW'(ret_o), '0);
    cop_valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b1, 2'b00, 1'b1, 2'd0, 7'd0, '0, '0); // R1 after release: empty

    // sweep command x device x valid x occupancy
    for (int ctx = 0; ctx < 2; ctx++)
      for (int op = 0; op < 4; op++)
        for (int sd = 0; sd < 2; sd++)
          for (int v = 0; v < 2; v++) begin
            int n = ((ctx * 4 + op) * 2 + sd) * 2 + v;
            logic [NB-1:0] m = 16'h00ff << (n % 9);
            if (ctx == 1) step(1'b1, 2'b01, 1'b1, 2'(n), 7'(n * 5), pat(n), m);
            step(1'(v), 2'(op), 1'(sd), 2'(n >> 1), 7'(n * 3 + 1), pat(n + 64), ~m);
            step(1'b0, 2'b00, 1'b0, 2'd0, 7'd0, '0, '0);
            step(1'b1, 2'b00, 1'b0, 2'd3, 7'd9, '0, '0);
          end

    // R8 forwarding with walking masks, hit and miss
    for (int k = 0; k < 32; k++) begin
      logic [NB-1:0] m;
      logic [1:0] bk = 2'(k);
      logic [6:0] cl = 7'(k * 7 + 2);
      m = (k == 0) ? 16'h0000 : (k == 31) ? 16'hffff : (16'h1 << (k % 16));
      if (k >= 16 && k != 31) m = ~m;
      step(1'b1, 2'b01, 1'b1, bk, cl, pat(k + 300), m);
      step(1'b1, 2'b10, 1'b1, bk, cl, '0, '0);
      step(1'b1, 2'b10, 1'b1, bk, cl ^ 7'h01, '0, '0);
      step(1'b1, 2'b10, 1'b1, bk ^ 2'b01, cl, '0, '0);
      step(1'b1, 2'b10, 1'b0, bk, cl, '0, '0);
      step(1'b1, 2'b10, 1'b1, bk, cl, '0, '0);
    end

    // R4 back-to-back local writes with interleaved local reads
    for (int k = 0; k < 200; k++) begin
      step(1'b1, 2'b01, 1'b1, 2'(k), 7'(k * 13), pat(k + 500), 16'(k * 2957));
      if (k % 3 == 0) step(1'b1, 2'b10, 1'b1, 2'(k), 7'(k * 13), '0, '0);
    end
    step(1'b1, 2'b11, 1'b1, 2'd0, 7'd0, '0, '0);
    step(1'b1, 2'b00, 1'b1, 2'd0, 7'd0, '0, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule